// File: doc/BRIEF.md
# GPIO Expander Port Register Core

This block holds the per-pin configuration of a 24-pin general-purpose I/O expander and turns it into pad control. A host reaches it through a plain byte-wide register port (write strobe, read strobe, address, data). That port takes the place of the serial target that would sit in front of it.

For every pin the core keeps these settings:
- direction;
- output data;
- input polarity inversion;
- pull-resistor enable and pull-up or pull-down select;
- drive mode, either push-pull or open-drain.

From these it produces registered output-enable, output-value and pull-enable signals for each pad. Pad inputs pass through a two-flop synchronizer, and the polarity mask is applied to them before they are reported.

Three reset sources bring the block back to the same all-input default:
- the synchronous power-on reset `rst`;
- an active-low hardware reset pin, which is synchronized first;
- a software reset, triggered by writing a key byte to a write-only control address.

Each 24-bit function occupies three consecutive byte addresses. The function code sits in address bits [4:2] and the byte lane in bits [1:0], least significant byte first. Addresses that are not defined read as zero and ignore writes.

Top module: `gpio_regcore`

## Requirements
- R1: After `rst`, every configuration register reads 0x00. `pad_oe`, `pad_out`, `pad_pu_en` and `pad_pd_en` are all zero, so every pin is an input with pulls off and push-pull drive.
- R2: Direction bit 1 makes the pin an output and 0 makes it an input. It is written at function code 3 (addresses 0x0C to 0x0E). A pin whose direction bit is 0 has `pad_oe` low. Pad signals reflect a write two clock edges after the write is sampled.
- R3: For an output pin in push-pull mode (drive bit 0), `pad_oe` is 1 and `pad_out` equals the output data bit. Output data is written at function code 1 (addresses 0x04 to 0x06).
- R4: Drive bit 1 selects open-drain. It is written at function code 6 (addresses 0x18 to 0x1A). For such a pin, `pad_out` is always 0 and `pad_oe` is high only when the pin is an output and its output data bit is 0.
- R5: Pull enable (function code 4, addresses 0x10 to 0x12) together with pull select (function code 5, addresses 0x14 to 0x16; 1 = up, 0 = down) gives the following. `pad_pu_en` is enable AND select, and `pad_pd_en` is enable AND NOT select.
- R6: Reading function code 0 (addresses 0x00 to 0x02) returns the pad input bits, XORed with polarity. The pads are synchronized through two flops, so the value is valid for a read issued three cycles after a pad change. Writes to these addresses are ignored.
- R7: A polarity bit of 1 (function code 2, addresses 0x08 to 0x0A) inverts that bit in the value read from the input port.
- R8: A read strobe produces `host_rvalid` high for exactly the next cycle, with `host_rdata` holding the addressed byte. Every configuration register reads back what was last written to it.
- R9: An undefined address reads as 0x00, and a write to it changes no register. Undefined addresses are byte lane 3 of any function code, function code 7 lanes 1 to 3, and anything above 0x1F.
- R10: Writing 0xA5 to address 0x1C restores the R1 defaults. The registers are cleared by the second clock edge after the write. Any other value written there is ignored, and a read of 0x1C returns 0x00.
- R11: Holding `rst_pin_n` low for at least three cycles restores the R1 defaults, and they stay in force while the pin remains low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Power-on reset, synchronous, active high |
| rst_pin_n | input | 1 | Hardware reset pin, active low, asynchronous to clk |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe |
| host_addr | input | ADDR_W | Register byte address |
| host_wdata | input | 8 | Write data byte |
| host_rdata | output | 8 | Read data byte, valid with host_rvalid |
| host_rvalid | output | 1 | Read data valid, one cycle after host_rd |
| pad_in | input | NPINS | Raw pad input levels |
| pad_oe | output | NPINS | Per-pad output enable |
| pad_out | output | NPINS | Per-pad output value |
| pad_pu_en | output | NPINS | Per-pad pull-up enable |
| pad_pd_en | output | NPINS | Per-pad pull-down enable |

## Verification
A corrupted configuration bit appears on the pad outputs two edges after it forms. It also appears in the readback of its byte on the cycle after the read strobe. A wrong drive-mode or pull-select bit shows as a mismatch between `pad_oe`, `pad_out` and the pull pair for that single pin. A broken synchronizer or polarity path shows only through input-port reads, which the bench issues three cycles after each pad change. A reset source that fails to clear state leaves non-zero readback and an enabled pad within two to four cycles of the reset event.

// File: rtl/gpio_regcore_pkg.sv
package gpio_regcore_pkg;

  // Address layout: addr[GRP_SHIFT+2:GRP_SHIFT] is the function code,
  // addr[GRP_SHIFT-1:0] the byte lane inside that function.
  localparam int GRP_SHIFT = 2;
  localparam int FN_W      = 3;
  localparam int BYTE_W    = 8;

  typedef enum logic [FN_W-1:0] {
    FN_IN   = 3'd0,
    FN_OUT  = 3'd1,
    FN_POL  = 3'd2,
    FN_DIR  = 3'd3,
    FN_PEN  = 3'd4,
    FN_PSEL = 3'd5,
    FN_DRV  = 3'd6,
    FN_CTL  = 3'd7
  } fn_e;

  localparam logic [BYTE_W-1:0] SWRST_KEY = 8'hA5;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W       = 1,
  parameter bit RST_VAL = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1_q <= {W{RST_VAL}};
      stage2_q <= {W{RST_VAL}};
    end else begin
      stage1_q <= d;
      stage2_q <= stage1_q;
    end
  end

  assign q = stage2_q;

endmodule

// File: rtl/gpio_reset_ctl.sv
module gpio_reset_ctl (
  input  logic clk,
  input  logic por,
  input  logic rst_pin_n,
  input  logic swrst_req,
  output logic core_rst
);

  logic pin_n_sync;
  logic swrst_q;

  // The pin is asynchronous to clk; synchronize it and park it inactive on POR.
  gpio_sync #(
    .W       (1),
    .RST_VAL (1'b1)
  ) pin_sync_i (
    .clk (clk),
    .rst (por),
    .d   (rst_pin_n),
    .q   (pin_n_sync)
  );

  // The software request becomes a one-cycle reset pulse on the next edge.
  always_ff @(posedge clk) begin
    if (por) swrst_q <= 1'b0;
    else     swrst_q <= swrst_req;
  end

  assign core_rst = por | ~pin_n_sync | swrst_q;

endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_regcore_pkg::*;
#(
  parameter int NPINS  = 24,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [NPINS-1:0]  in_sync,
  output logic [BYTE_W-1:0] rdata,
  output logic              rvalid,
  output logic              swrst_req,
  output logic [NPINS-1:0]  out_q,
  output logic [NPINS-1:0]  dir_q,
  output logic [NPINS-1:0]  pen_q,
  output logic [NPINS-1:0]  psel_q,
  output logic [NPINS-1:0]  drv_q
);

  localparam int NBYTES = (NPINS + BYTE_W - 1) / BYTE_W;
  localparam int PADW   = NBYTES * BYTE_W;
  localparam int NCFG   = 6;
  localparam int LANE_W = GRP_SHIFT;

  logic [NCFG-1:0][NPINS-1:0] cfg_q;
  logic [NCFG-1:0][NPINS-1:0] cfg_nxt;

  fn_e               fn;
  logic [LANE_W-1:0] lane;
  logic              hi_ok;
  logic              lane_ok;
  logic [2:0]        cfg_idx;
  logic [PADW-1:0]   wr_wide;
  logic [PADW-1:0]   rd_wide;
  logic [NPINS-1:0]  rd_word;
  logic [NPINS-1:0]  in_port;
  logic [BYTE_W-1:0] rdata_nxt;

  // Address decode shared by the write and read paths.
  assign fn      = fn_e'(addr[GRP_SHIFT +: FN_W]);
  assign lane    = addr[LANE_W-1:0];
  assign hi_ok   = (addr >> (GRP_SHIFT + FN_W)) == '0;
  assign lane_ok = int'(lane) < NBYTES;
  assign cfg_idx = addr[GRP_SHIFT +: FN_W] - 3'd1;

  // Reported input value: synchronized pads with the polarity mask applied.
  assign in_port = in_sync ^ cfg_q[FN_POL - 1];

  // Write path: byte-lane merge into the addressed configuration word.
  always_comb begin
    cfg_nxt   = cfg_q;
    swrst_req = 1'b0;
    wr_wide   = '0;
    if (wr_en && hi_ok) begin
      if (fn == FN_CTL) begin
        if (lane == '0) swrst_req = (wdata == SWRST_KEY);
      end else if (fn != FN_IN && lane_ok) begin
        wr_wide = PADW'(cfg_q[cfg_idx]);
        wr_wide[{lane, 3'b000} +: BYTE_W] = wdata;
        cfg_nxt[cfg_idx] = wr_wide[NPINS-1:0];
      end
    end
  end

  // Read path: choose the addressed word, then the addressed lane.
  always_comb begin
    rd_word   = '0;
    rd_wide   = '0;
    rdata_nxt = '0;
    if (hi_ok && lane_ok) begin
      case (fn)
        FN_IN:   rd_word = in_port;
        FN_CTL:  rd_word = '0;
        default: rd_word = cfg_q[cfg_idx];
      endcase
      rd_wide   = PADW'(rd_word);
      rdata_nxt = rd_wide[{lane, 3'b000} +: BYTE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= '0;
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      cfg_q  <= cfg_nxt;
      rvalid <= rd_en;
      if (rd_en) rdata <= rdata_nxt;
    end
  end

  assign out_q  = cfg_q[FN_OUT  - 1];
  assign dir_q  = cfg_q[FN_DIR  - 1];
  assign pen_q  = cfg_q[FN_PEN  - 1];
  assign psel_q = cfg_q[FN_PSEL - 1];
  assign drv_q  = cfg_q[FN_DRV  - 1];

endmodule

// File: rtl/gpio_pad_ctl.sv
module gpio_pad_ctl #(
  parameter int NPINS = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] out_q,
  input  logic [NPINS-1:0] dir_q,
  input  logic [NPINS-1:0] pen_q,
  input  logic [NPINS-1:0] psel_q,
  input  logic [NPINS-1:0] drv_q,
  output logic [NPINS-1:0] pad_oe,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_pu_en,
  output logic [NPINS-1:0] pad_pd_en
);

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    logic oe_d;
    logic out_d;
    logic pu_d;
    logic pd_d;

    // Open-drain pins only ever pull low; a 1 releases the driver.
    always_comb begin
      if (drv_q[p]) begin
        oe_d  = dir_q[p] & ~out_q[p];
        out_d = 1'b0;
      end else begin
        oe_d  = dir_q[p];
        out_d = out_q[p];
      end
      pu_d = pen_q[p] &  psel_q[p];
      pd_d = pen_q[p] & ~psel_q[p];
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        pad_oe[p]    <= 1'b0;
        pad_out[p]   <= 1'b0;
        pad_pu_en[p] <= 1'b0;
        pad_pd_en[p] <= 1'b0;
      end else begin
        pad_oe[p]    <= oe_d;
        pad_out[p]   <= out_d;
        pad_pu_en[p] <= pu_d;
        pad_pd_en[p] <= pd_d;
      end
    end
  end

endmodule

// File: rtl/gpio_regcore.sv
module gpio_regcore
  import gpio_regcore_pkg::*;
#(
  parameter int NPINS  = 24,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rst_pin_n,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  output logic              host_rvalid,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_oe,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_pu_en,
  output logic [NPINS-1:0]  pad_pd_en
);

  logic             core_rst;
  logic             swrst_req;
  logic [NPINS-1:0] in_sync;
  logic [NPINS-1:0] out_q;
  logic [NPINS-1:0] dir_q;
  logic [NPINS-1:0] pen_q;
  logic [NPINS-1:0] psel_q;
  logic [NPINS-1:0] drv_q;

  gpio_reset_ctl rst_ctl_i (
    .clk       (clk),
    .por       (rst),
    .rst_pin_n (rst_pin_n),
    .swrst_req (swrst_req),
    .core_rst  (core_rst)
  );

  gpio_sync #(
    .W       (NPINS),
    .RST_VAL (1'b0)
  ) in_sync_i (
    .clk (clk),
    .rst (core_rst),
    .d   (pad_in),
    .q   (in_sync)
  );

  gpio_regfile #(
    .NPINS  (NPINS),
    .ADDR_W (ADDR_W)
  ) regfile_i (
    .clk       (clk),
    .rst       (core_rst),
    .wr_en     (host_wr),
    .rd_en     (host_rd),
    .addr      (host_addr),
    .wdata     (host_wdata),
    .in_sync   (in_sync),
    .rdata     (host_rdata),
    .rvalid    (host_rvalid),
    .swrst_req (swrst_req),
    .out_q     (out_q),
    .dir_q     (dir_q),
    .pen_q     (pen_q),
    .psel_q    (psel_q),
    .drv_q     (drv_q)
  );

  gpio_pad_ctl #(
    .NPINS (NPINS)
  ) pad_ctl_i (
    .clk       (clk),
    .rst       (core_rst),
    .out_q     (out_q),
    .dir_q     (dir_q),
    .pen_q     (pen_q),
    .psel_q    (psel_q),
    .drv_q     (drv_q),
    .pad_oe    (pad_oe),
    .pad_out   (pad_out),
    .pad_pu_en (pad_pu_en),
    .pad_pd_en (pad_pd_en)
  );

endmodule

// File: rtl/gpio_regcore_chk.sv
module gpio_regcore_chk #(
  parameter int NPINS  = 24,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              rst_pin_n,
  input logic              host_wr,
  input logic              host_rd,
  input logic [ADDR_W-1:0] host_addr,
  input logic [7:0]        host_wdata,
  input logic [7:0]        host_rdata,
  input logic              host_rvalid,
  input logic [NPINS-1:0]  pad_oe,
  input logic [NPINS-1:0]  pad_pu_en,
  input logic [NPINS-1:0]  pad_pd_en
);

  localparam logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'(28);

  logic undef_addr;
  assign undef_addr = (host_addr[1:0] == 2'd3) ||
                      (host_addr >= ADDR_W'(29)) ||
                      (host_addr == CTL_ADDR);

  AST_RVALID_FROM_READ: assert property (@(posedge clk) disable iff (rst)
    host_rvalid |-> $past(host_rd)) else $error("rvalid without read"); // R8

  AST_UNDEF_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (host_rd && undef_addr) |=> host_rdata == 8'h00) else $error("undefined addr data"); // R9

  AST_SWRST_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (host_rd && host_addr == CTL_ADDR) |=> host_rdata == 8'h00) else $error("swrst readback"); // R10

  AST_SWRST_CLEARS_PADS: assert property (@(posedge clk) disable iff (rst)
    (host_wr && host_addr == CTL_ADDR && host_wdata == 8'hA5) |=> ##1
      (pad_oe == '0 && pad_pu_en == '0 && pad_pd_en == '0)) else $error("swrst pads"); // R10

  AST_PIN_RESET_CLEARS_PADS: assert property (@(posedge clk) disable iff (rst)
    (!rst_pin_n && !$past(rst_pin_n) && !$past(rst_pin_n, 2)) |=>
      (pad_oe == '0 && pad_pu_en == '0 && pad_pd_en == '0)) else $error("pin reset pads"); // R11

endmodule

bind gpio_regcore gpio_regcore_chk #(
  .NPINS  (NPINS),
  .ADDR_W (ADDR_W)
) chk_i (
  .clk         (clk),
  .rst         (rst),
  .rst_pin_n   (rst_pin_n),
  .host_wr     (host_wr),
  .host_rd     (host_rd),
  .host_addr   (host_addr),
  .host_wdata  (host_wdata),
  .host_rdata  (host_rdata),
  .host_rvalid (host_rvalid),
  .pad_oe      (pad_oe),
  .pad_pu_en   (pad_pu_en),
  .pad_pd_en   (pad_pd_en)
);

// File: tb/gpio_regcore_tb_top.sv
module gpio_regcore_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NPINS      = 24;
  localparam int ADDR_W     = 5;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              rst_pin_n = 1'b1;
  logic              host_wr = 1'b0;
  logic              host_rd = 1'b0;
  logic [ADDR_W-1:0] host_addr = '0;
  logic [7:0]        host_wdata = '0;
  logic [7:0]        host_rdata;
  logic              host_rvalid;
  logic [NPINS-1:0]  pad_in = '0;
  logic [NPINS-1:0]  pad_oe;
  logic [NPINS-1:0]  pad_out;
  logic [NPINS-1:0]  pad_pu_en;
  logic [NPINS-1:0]  pad_pd_en;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_regcore #(
    .NPINS  (NPINS),
    .ADDR_W (ADDR_W)
  ) dut_i (
    .clk         (clk),
    .rst         (rst),
    .rst_pin_n   (rst_pin_n),
    .host_wr     (host_wr),
    .host_rd     (host_rd),
    .host_addr   (host_addr),
    .host_wdata  (host_wdata),
    .host_rdata  (host_rdata),
    .host_rvalid (host_rvalid),
    .pad_in      (pad_in),
    .pad_oe      (pad_oe),
    .pad_out     (pad_out),
    .pad_pu_en   (pad_pu_en),
    .pad_pd_en   (pad_pd_en)
  );

  task automatic check24(string tag, logic [NPINS-1:0] act, logic [NPINS-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%06h expected=%06h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [ADDR_W-1:0] a, logic [7:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  // Driver: issue a read and push the expected byte for the monitor.
  task automatic rd(logic [ADDR_W-1:0] a, logic [7:0] exp, string tag);
    @(negedge clk);
    host_rd = 1'b1; host_addr = a;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pads(string tag, logic [NPINS-1:0] oe, logic [NPINS-1:0] o,
                      logic [NPINS-1:0] pu, logic [NPINS-1:0] pd);
    check24({tag, " oe"},  pad_oe,    oe);
    check24({tag, " out"}, pad_out,   o);
    check24({tag, " pu"},  pad_pu_en, pu);
    check24({tag, " pd"},  pad_pd_en, pd);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // Monitor: compare every returned read against the scoreboard queue.
  always @(negedge clk) begin
    if (host_rvalid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R8: unexpected read data actual=%02h expected=none", host_rdata);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (host_rdata !== e) begin
          errors++;
          $display("FAIL %s: actual=%02h expected=%02h", t, host_rdata, e);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    settle(5);
    rst = 1'b0;
    settle(2);

    // R1 defaults
    pads("R1 reset", '0, '0, '0, '0);
    rd(5'h0C, 8'h00, "R1 dir0");
    rd(5'h04, 8'h00, "R1 out0");
    rd(5'h18, 8'h00, "R1 drv0");

    // R2/R3 push-pull outputs
    wr(5'h04, 8'h5A); wr(5'h05, 8'hC3); wr(5'h06, 8'h0F);
    settle(2);
    check24("R2 inputs keep oe low", pad_oe, '0);
    wr(5'h0C, 8'hFF); wr(5'h0D, 8'hFF); wr(5'h0E, 8'hFF);
    settle(2);
    pads("R3 push-pull", 24'hFFFFFF, 24'h0FC35A, '0, '0);

    // R8 readback
    rd(5'h04, 8'h5A, "R8 out0");
    rd(5'h05, 8'hC3, "R8 out1");
    rd(5'h06, 8'h0F, "R8 out2");
    rd(5'h0E, 8'hFF, "R8 dir2");

    // R4 open-drain on the low byte
    wr(5'h18, 8'hFF);
    settle(2);
    pads("R4 open-drain", 24'hFFFFA5, 24'h0FC300, '0, '0);

    // R2 upper byte back to input
    wr(5'h0E, 8'h00);
    settle(2);
    check24("R2 upper input", pad_oe, 24'h00FFA5);

    // R5 pulls
    wr(5'h11, 8'hFF); wr(5'h15, 8'hF0);
    settle(2);
    check24("R5 pull-up", pad_pu_en, 24'h00F000);
    check24("R5 pull-down", pad_pd_en, 24'h000F00);

    // R6 input port, R7 polarity
    @(negedge clk); pad_in = 24'h123456;
    settle(3);
    rd(5'h00, 8'h56, "R6 in0");
    rd(5'h01, 8'h34, "R6 in1");
    rd(5'h02, 8'h12, "R6 in2");
    wr(5'h08, 8'hFF);
    rd(5'h00, 8'hA9, "R7 inverted in0");
    rd(5'h01, 8'h34, "R7 uninverted in1");
    wr(5'h00, 8'hFF);
    rd(5'h00, 8'hA9, "R6 input write ignored");

    // R9 undefined addresses
    wr(5'h03, 8'hFF); wr(5'h1F, 8'hFF); wr(5'h07, 8'h77);
    rd(5'h03, 8'h00, "R9 lane3 read");
    rd(5'h1F, 8'h00, "R9 ctl lane3 read");
    rd(5'h04, 8'h5A, "R9 out0 untouched");
    rd(5'h08, 8'hFF, "R9 pol0 untouched");
    settle(2);
    check24("R9 oe untouched", pad_oe, 24'h00FFA5);

    // R10 wrong key ignored, control reads zero
    wr(5'h1C, 8'h12);
    settle(2);
    rd(5'h0C, 8'hFF, "R10 wrong key dir kept");
    rd(5'h1C, 8'h00, "R10 ctl reads zero");
    check24("R10 wrong key oe kept", pad_oe, 24'h00FFA5);

    // R10 key resets everything
    wr(5'h1C, 8'hA5);
    settle(2);
    pads("R10 swrst", '0, '0, '0, '0);
    rd(5'h04, 8'h00, "R10 out0 cleared");
    rd(5'h08, 8'h00, "R10 pol0 cleared");
    rd(5'h00, 8'h56, "R10 input polarity cleared");

    // R11 hardware pin reset
    wr(5'h0C, 8'hFF); wr(5'h10, 8'h0F); wr(5'h14, 8'h03);
    settle(2);
    pads("R11 preset", 24'h0000FF, '0, 24'h000003, 24'h00000C);
    @(negedge clk); rst_pin_n = 1'b0;
    settle(5);
    pads("R11 held", '0, '0, '0, '0);
    rst_pin_n = 1'b1;
    settle(4);
    pads("R11 released", '0, '0, '0, '0);
    rd(5'h0C, 8'h00, "R11 dir cleared");
    rd(5'h10, 8'h00, "R11 pen cleared");

    settle(4);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R8: pending reads actual=%0d expected=0", exp_q.size());
    end
    done = 1'b1;
    summary();
    $finish;
  end

endmodule